// File: doc/BRIEF.md
# Sample Rate Ratio Tracker

This block estimates how fast input audio samples arrive compared with output samples. It counts input-sample strobes over a fixed window of output-sample strobes. It clamps that count to the supported span. It then moves a smoothed estimate part of the way toward each new measurement. The estimate is an unsigned fixed-point number with 2 integer bits and 10 fractional bits. It starts at exactly 1.0 after reset. A rate converter reads it to place its filters.

Two status outputs follow the input rate. A lock indicator stays in its unlocked state while successive window measurements keep moving. A model of the converter's data buffer raises an overflow flag when the input outruns the output for too long. The flag stays set until it is cleared.

Top module: `srt_ratio_tracker`

## Requirements
- R1: During and after synchronous reset, `ratio` reads 0x400 (1.0 in the 2.10 format), `unlock` is 1 and `ovf` is 0.
- R2: A measurement window closes on every 2^WIN_LOG2-th output strobe. The measured value is the number of input strobes seen in that window, including one in the same cycle as the closing output strobe, multiplied by 2^(10-WIN_LOG2). The input count saturates at 4·2^WIN_LOG2−1.
- R3: At each window close the estimate becomes est + ((meas − est) >>> SMOOTH_SH), where >>> is a signed shift that rounds toward minus infinity.
- R4: Before it is used, the measured value is clamped to the range 341 (one third) to 3072 (three), so `ratio` never leaves that range.
- R5: `ratio` changes only at the second clock edge after the clock edge that samples the window-closing output strobe. Between window closes it holds steady.
- R6: `unlock` falls only when STABLE_WINS consecutive windows (4 by default) have each measured within `tol` LSBs of the previous measurement, that is |meas − prev| < tol. The first window is compared against 1.0. Any window outside the tolerance raises `unlock` again at the same edge that the estimate updates.
- R7: The buffer occupancy starts at BUF_DEPTH/2 samples. Each input strobe adds one sample, and each output strobe removes `ratio` samples (fractional). The occupancy is floored at zero.
- R8: `ovf` sets on the edge where an input strobe would push the occupancy above BUF_DEPTH samples. The occupancy is then held at BUF_DEPTH. The flag stays set.
- R9: `ovf_clr` clears `ovf`. An overflow in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_stb | input | 1 | One-cycle pulse per input sample |
| out_stb | input | 1 | One-cycle pulse per output sample |
| tol | input | 12 | Stability tolerance in ratio LSBs |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| ratio | output | 12 | Smoothed ratio, unsigned 2.10 |
| unlock | output | 1 | High while the input rate is judged to be moving |
| ovf | output | 1 | Sticky buffer overflow flag |

## Verification
A corrupted window count or smoothing step shows at `ratio` two cycles after the very next window closes. A wrong clamp shows at the first window whose count lies beyond either end of the span. A bad stability counter shows as `unlock` falling one window early or late, or failing to rise again after a jump. A buffer occupancy error shifts the exact input strobe on which `ovf` rises, both from the half-full start and from an empty buffer. The bench models every window arithmetically, so the first divergence is caught in the window where it occurs.

// File: rtl/srt_pkg.sv
package srt_pkg;

    localparam int INT_W   = 2;
    localparam int FRAC_W  = 10;
    localparam int RATIO_W = INT_W + FRAC_W;

    typedef logic [RATIO_W-1:0] ratio_t;

    localparam ratio_t RATIO_ONE = ratio_t'(1 << FRAC_W);
    localparam ratio_t RATIO_MIN = ratio_t'((1 << FRAC_W) / 3);
    localparam ratio_t RATIO_MAX = ratio_t'(3 << FRAC_W);

    // result of one closed measurement window
    typedef struct packed {
        logic   vld;
        ratio_t val;
    } meas_t;

    function automatic ratio_t clamp_ratio(input logic [31:0] v);
        if (v < 32'(RATIO_MIN)) return RATIO_MIN;
        if (v > 32'(RATIO_MAX)) return RATIO_MAX;
        return v[RATIO_W-1:0];
    endfunction

    function automatic ratio_t abs_diff(input ratio_t a, input ratio_t b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

endpackage

// File: rtl/srt_window.sv
module srt_window
    import srt_pkg::*;
#(
    parameter int WIN_LOG2 = 10
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  in_stb,
    input  logic  out_stb,
    output meas_t meas
);
    localparam int CNT_W = WIN_LOG2 + 2;
    localparam int SHIFT = FRAC_W - WIN_LOG2;

    logic [WIN_LOG2-1:0] out_cnt_q;
    logic [CNT_W-1:0]    in_cnt_q;
    logic [CNT_W-1:0]    in_tot;
    logic                win_end;
    logic [31:0]         scaled;

    always_comb begin
        if (in_stb && (in_cnt_q != '1)) in_tot = in_cnt_q + CNT_W'(1);
        else                            in_tot = in_cnt_q;
        win_end = out_stb && (out_cnt_q == '1);
        scaled  = 32'(in_tot) << SHIFT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_cnt_q <= '0;
            in_cnt_q  <= '0;
            meas      <= '{vld: 1'b0, val: RATIO_ONE};
        end else begin
            meas.vld <= win_end;
            if (out_stb) out_cnt_q <= out_cnt_q + WIN_LOG2'(1);
            if (win_end) begin
                in_cnt_q <= '0;
                meas.val <= clamp_ratio(scaled);
            end else begin
                in_cnt_q <= in_tot;
            end
        end
    end
endmodule

// File: rtl/srt_smoother.sv
module srt_smoother
    import srt_pkg::*;
#(
    parameter int SMOOTH_SH   = 2,
    parameter int STABLE_WINS = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  meas_t  meas,
    input  ratio_t tol,
    output ratio_t est,
    output logic   unlock
);
    localparam int SC_W = $clog2(STABLE_WINS + 1);

    ratio_t                    prev_q;
    logic [SC_W-1:0]           stab_q;
    logic signed [RATIO_W:0]   diff;
    logic signed [RATIO_W:0]   step;
    logic signed [RATIO_W:0]   est_nxt;
    logic                      close_enough;

    always_comb begin
        diff         = $signed({1'b0, meas.val}) - $signed({1'b0, est});
        step         = diff >>> SMOOTH_SH;
        est_nxt      = $signed({1'b0, est}) + step;
        close_enough = abs_diff(meas.val, prev_q) < tol;
    end

    assign unlock = (stab_q < SC_W'(STABLE_WINS));

    always_ff @(posedge clk) begin
        if (rst) begin
            est    <= RATIO_ONE;
            prev_q <= RATIO_ONE;
            stab_q <= '0;
        end else if (meas.vld) begin
            est    <= est_nxt[RATIO_W-1:0];
            prev_q <= meas.val;
            if (!close_enough)                     stab_q <= '0;
            else if (stab_q < SC_W'(STABLE_WINS)) stab_q <= stab_q + SC_W'(1);
        end
    end
endmodule

// File: rtl/srt_buffer.sv
module srt_buffer
    import srt_pkg::*;
#(
    parameter int BUF_DEPTH = 64
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   in_stb,
    input  logic   out_stb,
    input  ratio_t ratio,
    input  logic   clr,
    output logic   ovf
);
    localparam int LIMIT = BUF_DEPTH << FRAC_W;
    localparam int OCC_W = $clog2(LIMIT + 1);
    localparam int SW    = OCC_W + 2;

    logic [OCC_W-1:0]   occ_q;
    logic signed [SW-1:0] add_v, sub_v, nxt;
    logic                over;

    always_comb begin
        add_v = in_stb  ? SW'(1 << FRAC_W) : '0;
        sub_v = out_stb ? SW'(ratio)       : '0;
        nxt   = $signed({2'b00, occ_q}) + add_v - sub_v;
        over  = nxt > $signed(SW'(LIMIT));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            occ_q <= OCC_W'(LIMIT / 2);
            ovf   <= 1'b0;
        end else begin
            if (nxt < 0)   occ_q <= '0;
            else if (over) occ_q <= OCC_W'(LIMIT);
            else           occ_q <= nxt[OCC_W-1:0];
            if (over)      ovf <= 1'b1;
            else if (clr)  ovf <= 1'b0;
        end
    end
endmodule

// File: rtl/srt_ratio_tracker.sv
module srt_ratio_tracker
    import srt_pkg::*;
#(
    parameter int WIN_LOG2    = 10,
    parameter int SMOOTH_SH   = 2,
    parameter int STABLE_WINS = 4,
    parameter int BUF_DEPTH   = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_stb,
    input  logic               out_stb,
    input  logic [RATIO_W-1:0] tol,
    input  logic               ovf_clr,
    output logic [RATIO_W-1:0] ratio,
    output logic               unlock,
    output logic               ovf
);
    meas_t  meas;
    ratio_t est;

    srt_window #(.WIN_LOG2(WIN_LOG2)) u_win (
        .clk(clk), .rst(rst), .in_stb(in_stb), .out_stb(out_stb), .meas(meas)
    );

    srt_smoother #(.SMOOTH_SH(SMOOTH_SH), .STABLE_WINS(STABLE_WINS)) u_smooth (
        .clk(clk), .rst(rst), .meas(meas), .tol(tol), .est(est), .unlock(unlock)
    );

    srt_buffer #(.BUF_DEPTH(BUF_DEPTH)) u_buf (
        .clk(clk), .rst(rst), .in_stb(in_stb), .out_stb(out_stb),
        .ratio(est), .clr(ovf_clr), .ovf(ovf)
    );

    assign ratio = est;
endmodule

// File: rtl/srt_ratio_tracker_chk.sv
module srt_ratio_tracker_chk
    import srt_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               in_stb,
    input logic               ovf_clr,
    input logic               meas_vld,
    input logic [RATIO_W-1:0] ratio,
    input logic               unlock,
    input logic               ovf
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ratio == RATIO_ONE && unlock && !ovf));

    assert_ratio_in_span_R4: assert property (@(posedge clk) disable iff (rst)
        (ratio >= RATIO_MIN && ratio <= RATIO_MAX));

    assert_ratio_moves_on_window_R5: assert property (@(posedge clk) disable iff (rst)
        !$past(meas_vld) |-> $stable(ratio));

    assert_lock_on_window_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(unlock) |-> $past(meas_vld));

    assert_ovf_from_input_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf) |-> $past(in_stb));

    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(ovf) && !$past(ovf_clr)) |-> ovf);
endmodule

bind srt_ratio_tracker srt_ratio_tracker_chk u_chk (
    .clk(clk), .rst(rst), .in_stb(in_stb), .ovf_clr(ovf_clr),
    .meas_vld(meas.vld), .ratio(ratio), .unlock(unlock), .ovf(ovf)
);

// File: tb/srt_ratio_tracker_tb.sv
module srt_ratio_tracker_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WIN_LOG2   = 4;
    localparam int N          = 1 << WIN_LOG2;
    localparam int SCALE      = 1 << (10 - WIN_LOG2);
    localparam int SH         = 2;
    localparam int DEPTH      = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_stb = 1'b0, out_stb = 1'b0, ovf_clr = 1'b0;
    logic [11:0] tol = 12'd64;
    logic [11:0] ratio;
    logic        unlock, ovf;

    int checks = 0, errors = 0;
    int m_est, m_prev, m_stab;

    always #(CLK_PERIOD/2) clk = ~clk;

    srt_ratio_tracker #(.WIN_LOG2(WIN_LOG2), .SMOOTH_SH(SH), .STABLE_WINS(4),
                        .BUF_DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .in_stb(in_stb), .out_stb(out_stb), .tol(tol),
        .ovf_clr(ovf_clr), .ratio(ratio), .unlock(unlock), .ovf(ovf)
    );

    task automatic check(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse(input logic i, input logic o, input logic c);
        @(negedge clk);
        in_stb = i; out_stb = o; ovf_clr = c;
        @(negedge clk);
        in_stb = 0; out_stb = 0; ovf_clr = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        m_est = 1024; m_prev = 1024; m_stab = 0;
        @(negedge clk);
        check(ratio, 1024, "R1 ratio");
        check(unlock, 1, "R1 unlock");
        check(ovf, 0, "R1 ovf");
    endtask

    // one window with k input strobes spread over N output strobes
    task automatic run_window(input int k, input logic last_same);
        int m, d;
        for (int i = 0; i < N; i++) begin
            int nin = ((i + 1) * k) / N - (i * k) / N;
            if (last_same && i == N - 1 && nin > 0) nin--;
            for (int j = 0; j < nin; j++) pulse(1, 0, 0);
            if (last_same && i == N - 1 && k > 0) pulse(1, 1, 0);
            else pulse(0, 1, 0);
            if (i == N / 2) check(ratio, m_est, "R5 hold mid-window");
        end
        repeat (3) @(negedge clk);
        m = (k > 4 * N - 1 ? 4 * N - 1 : k) * SCALE;
        if (m < 341) m = 341;
        if (m > 3072) m = 3072;
        d = (m > m_prev) ? m - m_prev : m_prev - m;
        if (d < int'(tol)) m_stab = (m_stab < 4) ? m_stab + 1 : 4;
        else m_stab = 0;
        m_prev = m;
        m_est = m_est + ((m - m_est) >>> SH);
        check(ratio, m_est, "R2 R3 R4 ratio");
        check(unlock, (m_stab < 4) ? 1 : 0, "R6 unlock");
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();
        // R6: lock after four steady windows, lost on a jump
        tol = 12'd64;
        for (int w = 0; w < 5; w++) run_window(16, 0);
        run_window(20, 0);
        // R2/R4: sweep of every count including both clamp ends
        for (int k = 0; k < 64; k++) run_window(k, k[0]);
        for (int w = 0; w < 6; w++) run_window(24, 1);
        // R6: wider tolerance accepts small wobble
        tol = 12'd200;
        for (int w = 0; w < 8; w++) run_window(24 + (w % 3), w[0]);
        run_window(40, 0);

        // R7 R8 R9 buffer behaviour
        do_reset();
        for (int i = 0; i < DEPTH / 2; i++) pulse(1, 0, 0);
        check(ovf, 0, "R8 full but not over");
        pulse(1, 0, 0);
        check(ovf, 1, "R8 overflow sets");
        repeat (4) @(negedge clk);
        check(ovf, 1, "R8 sticky");
        pulse(0, 0, 1);
        check(ovf, 0, "R9 clear");
        pulse(1, 0, 1);
        check(ovf, 1, "R9 set wins over clear");
        pulse(0, 0, 1);
        check(ovf, 0, "R9 clear again");
        for (int i = 0; i < 200; i++) pulse(0, 1, 0);
        check(ovf, 0, "R7 drain no flag");
        for (int i = 0; i < DEPTH; i++) pulse(1, 0, 0);
        check(ovf, 0, "R7 floor at zero then fill");
        pulse(1, 0, 0);
        check(ovf, 1, "R7 R8 overflow from empty");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule